// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

This block is a programmable interval timer with a 64-bit counter. Software reaches it over a simple 32-bit register port, where every access is a single cycle with address, write strobe, read strobe and data. A prescaler divides the input clock by a factor from 1 to 16. On each prescaled tick the counter advances by one. When the counter reaches the programmed period, it returns to zero and raises a sticky elapsed flag. The timer can run once (one-shot) or repeat without stopping (continuous). If the period is set to all ones, the block acts as a free-running 64-bit time base.

The 64-bit period and count do not fit in one 32-bit register, so each is split into a low word and a high word. For the period, the two words are collected in a staging copy. The comparator only takes that copy when the timer starts or when a period wraps, so it never sees a half-written value. For the count, reading the low word captures the high word in the same cycle. A following read of the high word then returns a value that matches the low word, even if a carry happened between the two reads.

The width of a half-word is a parameter, `HALF_W`, with a default of 32, and the counter is twice that width. All register fields are zero-extended to 32 bits when read.

Top module: `pit64_timer`

## Requirements
- R1: After `rst_n` is asserted low, the count is 0, `running` and `elapsed` are low, and every register reads 0.
- R2: Writing 1 to bit 0 at offset 0x00 while the timer is stopped clears the count and the prescaler and sets `running`. The same write while the timer is running has no effect on the count. Reading offset 0x00 returns `running` in bit 0.
- R3: The prescaler field is bits 11:8 at offset 0x04 and holds a value N. While running, the count advances once every N+1 clock cycles. The first advance comes N+1 cycles after the start write.
- R4: The period is written as a low half at offset 0x08 and a high half at offset 0x0C. On a tick where the count equals the period, the count becomes 0 and `elapsed` is set.
- R5: Bit 0 at offset 0x04 selects the mode. When it is 1 (continuous), counting continues after a wrap. When it is 0 (one-shot), `running` falls at the wrap and the count stays at 0.
- R6: A write to a period register while the timer is running does not change the active period until the next wrap.
- R7: Reading the low count word at offset 0x20 captures the high count word. Reading the high count word at offset 0x24 returns that captured value.
- R8: Writing 1 to bit 8 at offset 0x00 clears the count, the prescaler, the mode, the period, the captured high word, `running` and `elapsed`. This soft reset wins over a start bit written in the same access, and the reset bit reads back as 0.
- R9: Bit 0 at offset 0x10 reads `elapsed`. Writing 1 there clears it, unless a wrap occurs in the same cycle, in which case it stays set.
- R10: With the period set to all ones, the count passes through the all-ones value and then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high |
| running | output | 1 | Timer is counting |
| elapsed | output | 1 | Sticky flag: a period has elapsed |

## Verification
The hardest case to reach is a carry from the low count word into the high word that lands between the two halves of a readback. With a 64-bit counter, that carry is out of reach within a practical run. The bench therefore builds the timer with 8-bit halves and runs it with no prescaling. It then reads the low word exactly when the word is at 0xFF, so the very next edge carries into the high word before the high read. The same narrow build makes the all-ones free-running wrap reachable in about 65,000 cycles. A further test rewrites the period in the middle of a run to show the old period is kept until the wrap.

// File: rtl/pit64_timer.sv
module pit64_timer #(
  parameter int HALF_W = 32,
  parameter int PSC_W  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              running,
  output logic              elapsed
);
  localparam int CNT_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(8'h24);

  logic              cont;
  logic [PSC_W-1:0]  psc, div;
  logic [CNT_W-1:0]  per_stage, per_act, cnt;
  logic [HALF_W-1:0] shadow;
  logic              run_q, elap_q;

  wire w_ctrl = wr_en && addr == A_CTRL;
  wire swrst  = w_ctrl && wdata[8];
  wire go     = w_ctrl && wdata[0] && !wdata[8] && !run_q;
  wire tick   = run_q && div >= psc;
  wire hit    = tick && cnt == per_act;
  wire clr_el = wr_en && addr == A_STAT && wdata[0];
  wire rd_lo  = rd_en && addr == A_CLO;

  assign running = run_q;
  assign elapsed = elap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont <= 1'b0; psc <= '0; div <= '0; per_stage <= '0; per_act <= '0;
      cnt <= '0; shadow <= '0; run_q <= 1'b0; elap_q <= 1'b0;
    end else if (swrst) begin
      cont <= 1'b0; psc <= '0; div <= '0; per_stage <= '0; per_act <= '0;
      cnt <= '0; shadow <= '0; run_q <= 1'b0; elap_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_MODE) begin
        cont <= wdata[0];
        psc  <= wdata[8 +: PSC_W];
      end
      if (wr_en && addr == A_PLO) per_stage[HALF_W-1:0]     <= wdata[HALF_W-1:0];
      if (wr_en && addr == A_PHI) per_stage[CNT_W-1:HALF_W] <= wdata[HALF_W-1:0];

      if (go) begin
        cnt     <= '0;
        div     <= '0;
        run_q   <= 1'b1;
        per_act <= per_stage;
      end else if (tick) begin
        div <= '0;
        if (hit) begin
          cnt     <= '0;
          per_act <= per_stage;
          if (!cont) run_q <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (run_q) begin
        div <= div + 1'b1;
      end

      if (hit) elap_q <= 1'b1;
      else if (clr_el) elap_q <= 1'b0;

      if (rd_lo) shadow <= cnt[CNT_W-1:HALF_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL: rdata[0] = run_q;
        A_MODE: begin rdata[0] = cont; rdata[8 +: PSC_W] = psc; end
        A_PLO:  rdata[HALF_W-1:0] = per_stage[HALF_W-1:0];
        A_PHI:  rdata[HALF_W-1:0] = per_stage[CNT_W-1:HALF_W];
        A_STAT: rdata[0] = elap_q;
        A_CLO:  rdata[HALF_W-1:0] = cnt[HALF_W-1:0];
        A_CHI:  rdata[HALF_W-1:0] = shadow;
        default: rdata = '0;
      endcase
    end
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> cnt == '0 && div == '0);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) |-> cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0);

  assert_count_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt <= per_act);

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> cnt == '0);

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo && !swrst |=> $stable(shadow));

  assert_elapsed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    elap_q && !clr_el && !swrst |=> elap_q);
endmodule

// File: tb/tb_pit64_timer.sv
module tb_pit64_timer;
  localparam logic [5:0] CTRL = 6'h00, MODE = 6'h04, PLO = 6'h08, PHI = 6'h0C,
                         STAT = 6'h10, CLO = 6'h20, CHI = 6'h24;

  typedef struct packed {
    logic [3:0]  psc;
    logic [15:0] per;
    logic        cont;
    logic [17:0] n;
    logic [15:0] cnt;
    logic        el;
    logic        run;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd0,  16'd5,     1'b1, 18'd3,   16'd3, 1'b0, 1'b1},
    '{4'd0,  16'd5,     1'b1, 18'd8,   16'd2, 1'b1, 1'b1},
    '{4'd3,  16'd100,   1'b1, 18'd21,  16'd5, 1'b0, 1'b1},
    '{4'd0,  16'd4,     1'b0, 18'd7,   16'd0, 1'b1, 1'b0},
    '{4'd15, 16'd2,     1'b0, 18'd40,  16'd2, 1'b0, 1'b1},
    '{4'd1,  16'h0102,  1'b1, 18'd520, 16'd1, 1'b1, 1'b1},
    '{4'd0,  16'd0,     1'b1, 18'd5,   16'd0, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, d;
  logic running, elapsed;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pit64_timer #(.HALF_W(8), .PSC_W(4), .ADDR_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .running(running), .elapsed(elapsed));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic setup(input logic [3:0] p, input logic c, input logic [15:0] per);
    wr(CTRL, 32'h100);
    wr(MODE, {20'd0, p, 7'd0, c});
    wr(PLO, {24'd0, per[7:0]});
    wr(PHI, {24'd0, per[15:8]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 running", {31'd0, running}, 0);
    chk("R1 elapsed", {31'd0, elapsed}, 0);
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(MODE, d); chk("R1 mode", d, 0);
    rd(PLO, d);  chk("R1 per lo", d, 0);
    rd(CLO, d);  chk("R1 cnt lo", d, 0);
    rd(CHI, d);  chk("R1 cnt hi", d, 0);

    // vector table: R3 prescale, R4 wrap, R5 modes
    for (int i = 0; i < 7; i++) begin
      setup(VECS[i].psc, VECS[i].cont, VECS[i].per);
      wr(CTRL, 32'h1);
      repeat (int'(VECS[i].n)) @(negedge clk);
      chk($sformatf("R4 vec%0d elapsed", i), {31'd0, elapsed}, {31'd0, VECS[i].el});
      chk($sformatf("R5 vec%0d running", i), {31'd0, running}, {31'd0, VECS[i].run});
      rd(CLO, d); chk($sformatf("R3 vec%0d cnt lo", i), d, {24'd0, VECS[i].cnt[7:0]});
      rd(CHI, d); chk($sformatf("R4 vec%0d cnt hi", i), d, {24'd0, VECS[i].cnt[15:8]});
    end

    // R8 soft reset wins over start
    wr(CTRL, 32'h101);
    chk("R8 running", {31'd0, running}, 0);
    chk("R8 elapsed", {31'd0, elapsed}, 0);
    repeat (3) @(negedge clk);
    rd(CLO, d);  chk("R8 cnt", d, 0);
    rd(MODE, d); chk("R8 mode", d, 0);
    rd(CTRL, d); chk("R8 ctrl readback", d, 0);

    // R2 start while running is ignored
    setup(4'd0, 1'b1, 16'd100);
    wr(CTRL, 32'h1);
    rd(CTRL, d); chk("R2 running bit", d, 32'h1);
    repeat (9) @(negedge clk);
    wr(CTRL, 32'h1);
    repeat (4) @(negedge clk);
    rd(CLO, d); chk("R2 restart ignored", d, 15);

    // R9 clear, and set wins over clear
    setup(4'd0, 1'b1, 16'd2);
    wr(CTRL, 32'h1);
    repeat (5) @(negedge clk);
    chk("R9 set", {31'd0, elapsed}, 1);
    wr(STAT, 32'h1);
    chk("R9 set beats clear", {31'd0, elapsed}, 1);
    wr(STAT, 32'h1);
    chk("R9 cleared", {31'd0, elapsed}, 0);
    rd(STAT, d); chk("R9 status read", d, 0);

    // R6 period write deferred to wrap
    setup(4'd0, 1'b1, 16'd9);
    wr(CTRL, 32'h1);
    wr(PLO, 32'h3);
    repeat (5) @(negedge clk);
    rd(CLO, d); chk("R6 old period kept", d, 6);
    repeat (6) @(negedge clk);
    rd(CLO, d); chk("R6 new period top", d, 3);
    rd(CLO, d); chk("R6 new period wrap", d, 0);

    // R7 coherent readback across carry
    setup(4'd0, 1'b1, 16'hFFFF);
    wr(CTRL, 32'h1);
    repeat (255) @(negedge clk);
    rd(CLO, d); chk("R7 lo before carry", d, 32'hFF);
    rd(CHI, d); chk("R7 hi snapshot", d, 0);
    rd(CLO, d); chk("R7 lo after carry", d, 32'h01);

    // R10 free-running wrap
    setup(4'd0, 1'b1, 16'hFFFF);
    wr(CTRL, 32'h1);
    repeat (65535) @(negedge clk);
    chk("R10 no elapse before top", {31'd0, elapsed}, 0);
    rd(CLO, d); chk("R10 lo at top", d, 32'hFF);
    rd(CHI, d); chk("R10 hi at top", d, 32'hFF);
    chk("R10 elapsed after wrap", {31'd0, elapsed}, 1);
    rd(CLO, d); chk("R10 count after wrap", d, 32'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule